// File: doc/BRIEF.md
# Clock Output Divider with Half-Integer Ratio

This block derives a slower clock from a fast input clock. In integer mode the output period is a programmed whole number of input cycles. A mode bit selects a fixed ratio of 4.5 instead, which the 4 and 5 integer settings cannot give. In that mode the output transitions alternate between rising and falling input edges, so one output period spans nine input half-periods.

The divisor and mode bit come from a control register. They are sampled once, on the first rising input edge after the active-low divider reset is released. They then stay fixed until that reset is pulsed again. Software changes the ratio by writing the new value and then toggling the reset.

Top module: `clk_div_frac`

## Requirements
- R1: In integer mode with divisor N (2 to 255), the output is periodic with a period of exactly N input clock cycles.
- R2: In integer mode, the output is high for floor(N/2) input cycles and low for the rest. An even N gives a 50% duty cycle. An odd N gives a high phase one input cycle shorter than the low phase.
- R3: A divisor value of 0 or 1 behaves as divide-by-2, with one cycle high and one cycle low.
- R4: When `half_mode_i` is 1, each output period lasts 9 input half-periods: 4 half-periods high, then 5 low. Successive periods start alternately on a rising and a falling input edge.
- R5: While `half_mode_i` is 1, the value on `div_val_i` has no effect on the output.
- R6: While `rst_ni` is 0, `clk_o` is 0 regardless of the clock, and all counters are cleared.
- R7: The divisor and mode are captured on the first rising `clk_i` edge after `rst_ni` goes high. Later changes to `div_val_i` or `half_mode_i` have no effect until `rst_ni` is pulsed low again.
- R8: `clk_o` stays 0 through the capturing edge and first rises on the next rising `clk_i` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock; both edges are used |
| rst_ni | input | 1 | Active-low asynchronous divider reset from the control register |
| div_val_i | input | 8 | Integer divisor; values below 2 act as 2 |
| half_mode_i | input | 1 | 1 selects divide-by-4.5 and overrides `div_val_i` |
| clk_o | output | 1 | Divided clock |

## Verification
After a reset release, the capturing edge leaves `clk_o` low. The next rising edge sets it high. These two instants are probed directly, a quarter period after each edge.

From then on, every output period completes one input-cycle-counted interval after its first rising edge. A monitor samples `clk_o` a quarter period after every input edge, including falling edges. It measures the high and low lengths of each completed period in half-periods and compares them with expectations queued by the driver before the release.

Retuning without a reset is checked by queuing more periods of the old ratio. The asynchronous reset is checked one nanosecond after it is asserted.

// File: rtl/clk_div_frac_pkg.sv
package clk_div_frac_pkg;
  // divide-by-4.5 schedule over a 9-cycle frame (count runs 1..9)
  localparam int unsigned HALF_TOP   = 9;
  localparam int unsigned HALF_POS_H = 2;  // rising-edge pulse covers counts 1..2
  localparam int unsigned HALF_NEG_A = 5;  // falling-edge pulse sampled at counts 5..6
  localparam int unsigned HALF_NEG_B = 6;
  localparam int unsigned MIN_DIV    = 2;

  function automatic int unsigned cnt_width(int unsigned w);
    return (w > 4) ? w : 4;
  endfunction
endpackage

// File: rtl/clk_div_frac_cfg.sv
module clk_div_frac_cfg
  import clk_div_frac_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = cnt_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  div_val_i,
  input  logic          half_mode_i,
  output logic          run_o,
  output logic          half_o,
  output logic [CW-1:0] top_o,
  output logic [CW-1:0] hi_o
);
  logic [CW-1:0] int_top;

  always_comb begin
    int_top = CW'(div_val_i);
    if (div_val_i < W'(MIN_DIV)) int_top = CW'(MIN_DIV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      half_o <= 1'b0;
      top_o  <= '0;
      hi_o   <= '0;
    end else if (!run_o) begin
      run_o  <= 1'b1;
      half_o <= half_mode_i;
      top_o  <= half_mode_i ? CW'(HALF_TOP) : int_top;
      hi_o   <= half_mode_i ? CW'(HALF_POS_H) : (int_top >> 1);
    end
  end

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> ($stable(top_o) && $stable(half_o) && $stable(hi_o)));

  p_min_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (top_o >= CW'(MIN_DIV)));
endmodule

// File: rtl/clk_div_frac_count.sv
module clk_div_frac_count
  import clk_div_frac_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = cnt_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  always_comb begin
    if (!run_i)               cnt_nxt_o = '0;
    else if (cnt_o >= top_i)  cnt_nxt_o = CW'(1);
    else                      cnt_nxt_o = cnt_o + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_nxt_o;
  end

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= top_i);

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_o == top_i) |=> (cnt_o == CW'(1)));
endmodule

// File: rtl/clk_div_frac_phase.sv
module clk_div_frac_phase
  import clk_div_frac_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = cnt_width(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          half_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          clk_o
);
  logic pos_q, neg_q;

  // rising-edge half of the waveform
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= 1'b0;
    else         pos_q <= run_i && (cnt_nxt_i != '0) && (cnt_nxt_i <= hi_i);
  end

  // falling-edge half, only used for the 4.5 ratio
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= run_i && half_i &&
                          (cnt_i == CW'(HALF_NEG_A) || cnt_i == CW'(HALF_NEG_B));
  end

  assign clk_o = pos_q | neg_q;

  p_neg_half_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_i |-> !neg_q);

  p_rise_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pos_q) |-> (cnt_i == CW'(1)));

  p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_q && neg_q));
endmodule

// File: rtl/clk_div_frac.sv
module clk_div_frac
  import clk_div_frac_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_val_i,
  input  logic         half_mode_i,
  output logic         clk_o
);
  localparam int unsigned CW = cnt_width(W);

  logic          run, half;
  logic [CW-1:0] top, hi, cnt, cnt_nxt;

  clk_div_frac_cfg #(.W(W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_val_i   (div_val_i),
    .half_mode_i (half_mode_i),
    .run_o       (run),
    .half_o      (half),
    .top_o       (top),
    .hi_o        (hi)
  );

  clk_div_frac_count #(.W(W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .top_i     (top),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  clk_div_frac_phase #(.W(W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .half_i    (half),
    .hi_i      (hi),
    .cnt_i     (cnt),
    .cnt_nxt_i (cnt_nxt),
    .clk_o     (clk_o)
  );

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_rst_low_r6: assert (!clk_o && cnt == '0);
    end
  end
endmodule

// File: tb/tb_clk_div_frac.sv
module tb_clk_div_frac;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         half_i = 1'b0;
  logic [W-1:0] div_i = '0;
  logic         clk_o;

  typedef struct {
    int    hi;
    int    lo;
    string req;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   errors = 0;
  int   hidx = 0;
  int   rise_idx = 0;
  int   fall_idx = 0;
  bit   have_rise = 1'b0;
  logic prev_o = 1'b0;
  exp_t e;

  clk_div_frac #(.W(W)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_val_i   (div_i),
    .half_mode_i (half_i),
    .clk_o       (clk_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", req, act, expv);
    end
  endtask

  // monitor: sample a quarter period after every input edge, measure in half-periods
  initial begin
    forever begin
      @(clk_i);
      #(QTR);
      hidx++;
      if (!rst_ni) begin
        have_rise = 1'b0;
      end else begin
        if (clk_o && !prev_o) begin
          if (have_rise && q.size() > 0) begin
            e = q.pop_front();
            vectors++;
            if ((fall_idx - rise_idx) != e.hi || (hidx - fall_idx) != e.lo) begin
              errors++;
              $display("FAIL %s: high/low halves %0d/%0d, expected %0d/%0d",
                       e.req, fall_idx - rise_idx, hidx - fall_idx, e.hi, e.lo);
            end
          end
          rise_idx  = hidx;
          have_rise = 1'b1;
        end
        if (!clk_o && prev_o) fall_idx = hidx;
      end
      prev_o = clk_o;
    end
  end

  task automatic push_int(int n, int cnt, string req);
    exp_t x;
    for (int i = 0; i < cnt; i++) begin
      x.hi = 2 * (n / 2);
      x.lo = 2 * (n - n / 2);
      x.req = req;
      q.push_back(x);
    end
  endtask

  task automatic push_half(int cnt, string req);
    exp_t x;
    for (int i = 0; i < cnt; i++) begin
      x.hi = 4;
      x.lo = 5;
      x.req = req;
      q.push_back(x);
    end
  endtask

  // reset, program, release; probe the first two rising edges (R8)
  task automatic start(int val, bit half);
    rst_ni = 1'b0;
    @(negedge clk_i);
    div_i  = W'(val);
    half_i = half;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #(QTR);
    check(clk_o == 1'b0, "R8 low after capture edge", int'(clk_o), 0);
    @(posedge clk_i);
    #(QTR);
    check(clk_o == 1'b1, "R8 high one cycle later", int'(clk_o), 1);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run not finished, got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk_i);
    check(clk_o == 1'b0, "R6 output low in reset", int'(clk_o), 0);
    #(QTR);
    check(clk_o == 1'b0, "R6 output low in reset (high phase)", int'(clk_o), 0);

    push_int(4, 4, "R1 R2 N=4");   start(4, 0);   drain();
    push_int(5, 3, "R2 N=5 odd");  start(5, 0);   drain();
    push_int(2, 4, "R1 N=2");      start(2, 0);   drain();
    push_int(3, 3, "R2 N=3 odd");  start(3, 0);   drain();
    push_int(2, 3, "R3 N=0");      start(0, 0);   drain();
    push_int(2, 3, "R3 N=1");      start(1, 0);   drain();
    push_int(255, 2, "R1 N=255");  start(255, 0); drain();
    push_int(8, 2, "R1 R2 N=8");   start(8, 0);   drain();

    push_half(4, "R4 4.5 ratio");          start(4, 1);   drain();
    push_half(4, "R5 divisor 200 ignored"); start(200, 1); drain();
    push_half(3, "R5 divisor 0 ignored");   start(0, 1);   drain();

    // R7: retune without reset keeps the old ratio
    push_int(4, 3, "R7 before change"); start(4, 0); drain();
    div_i = W'(6);
    push_int(4, 4, "R7 divisor change ignored"); drain();
    half_i = 1'b1;
    push_int(4, 2, "R7 mode change ignored"); drain();
    half_i = 1'b0;
    push_int(6, 3, "R7 new value after reset toggle"); start(6, 0); drain();

    // R6: asynchronous reset while output is high
    @(posedge clk_o);
    #1;
    rst_ni = 1'b0;
    #1;
    check(clk_o == 1'b0, "R6 async clear", int'(clk_o), 0);
    repeat (4) @(posedge clk_i);
    #(QTR);
    check(clk_o == 1'b0, "R6 held low", int'(clk_o), 0);

    summary();
    $finish;
  end
endmodule